// File: doc/BRIEF.md
# Three-Channel Triggered DMA Engine

This block moves data between memory locations without processor involvement. Each of its three channels holds a programmed source address, destination address and unit count. It also holds an address-step setting for each side, a byte or word width for each side, and a transfer mode. A rising edge on a channel's trigger input starts work for that channel. Units move over a single-port request/ready memory bus as one read followed by one write. The block holds the processor off the bus while it owns it.

The transfer kind is one unit per trigger, a whole block per trigger, or a block with two free processor cycles after every fourth unit. Each kind can be marked repeating. Channels compete under a fixed order or a rotating order, and a channel that holds the bus is never preempted. When a channel's working count runs out, the channel sets its completion flag. An encoded vector reports the most urgent enabled flag, and reading the vector clears that flag. An abort input, gated by an enable, can stop a transfer cleanly.

Top module: `dma3`

## Requirements
- R1: After each unit the working source and destination addresses step independently by their 2-bit step field (0 or 3 hold, 1 add, 2 subtract). The step size is 1 for a byte-wide side and 2 for a word-wide side. Words are little-endian.
- R2: Setting a channel's enable copies the programmed source, destination and count into working registers. When the working count reaches zero, the count reloads from the programmed value and the channel flag sets. The working addresses are not reloaded, so a repeated channel continues from where it stopped.
- R3: When the programmed count is zero, a trigger is ignored and no bus request is made.
- R4: The 3-bit mode field has bit 2 for repeat and bits 1:0 for the kind: 0 single, 1 block, 2 burst-block. In single kind each trigger rising edge moves one unit. A non-repeated channel clears its enable when the count runs out. A repeated channel keeps it.
- R5: A trigger on a channel while that channel is running a block or burst-block is ignored.
- R6: In a burst-block, after every fourth unit that does not end the block, cpu_hold is low and mem_req is low for exactly two cycles. A repeated burst-block starts again without a trigger until its enable is cleared.
- R7: Word source to byte destination writes only the low source byte. Byte source to word destination writes the byte with the upper destination byte cleared. A byte read returns the data in mem_rdata[7:0].
- R8: With rr_en low, the lowest-numbered requesting channel wins. With rr_en high, the search starts after the channel that last finished. A transfer in progress (one unit in single kind, a whole block otherwise) is never preempted.
- R9: vec equals 2*(n+1) for the lowest-numbered channel n whose flag and ie bit are both set, and 0 when no such channel exists. A vec_rd pulse clears only that channel's flag.
- R10: After a trigger edge, the first idle cycle grants the channel. Each unit then has a read phase and a write phase, each held until mem_ready, followed by one wait cycle with cpu_hold high and no request.
- R11: While abort_en is high, abort stops the running transfer at its next unit boundary, clears the channel enable and drops its pending request. While abort_en is low, abort has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trig | input | NCH | Per-channel trigger, rising edge |
| en_set | input | NCH | Pulse: enable channel and load working registers |
| en_clr | input | NCH | Pulse: clear channel enable |
| ie | input | NCH | Per-channel vector enable |
| rr_en | input | 1 | Rotating priority select |
| abort | input | 1 | Abort request |
| abort_en | input | 1 | Gate for abort |
| src_addr | input | NCH*AW | Programmed source addresses |
| dst_addr | input | NCH*AW | Programmed destination addresses |
| xfer_cnt | input | NCH*CW | Programmed unit counts |
| src_step | input | 2*NCH | Source step fields |
| dst_step | input | 2*NCH | Destination step fields |
| src_byte | input | NCH | Source side is byte wide |
| dst_byte | input | NCH | Destination side is byte wide |
| mode | input | 3*NCH | Transfer mode fields |
| vec_rd | input | 1 | Vector read pulse |
| vec | output | VW | Encoded pending vector |
| en_o | output | NCH | Channel enables |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write |
| mem_byte | output | 1 | Byte-wide access |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Bus completes access this cycle |
| cpu_hold | output | 1 | Processor held off the bus |

## Verification
The bench uses the defaults NCH=3, AW=8 and CW=8 against a 256-byte memory model whose ready line can stall at random. Eight-bit addresses let decrementing destinations and fixed sources fall in a small region that the bench fully tracks. Three channels cover both priority orders and a preemption attempt, and they give two channels whose flags are masked differently in the vector. Counts of up to eight reach a burst-block with a mid-block gap and an abort landing inside a block.

// File: rtl/dma3.sv
module dma3 #(
  parameter int NCH = 3,
  parameter int AW  = 8,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int VW  = $clog2(2*NCH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    trig,
  input  logic [NCH-1:0]    en_set,
  input  logic [NCH-1:0]    en_clr,
  input  logic [NCH-1:0]    ie,
  input  logic              rr_en,
  input  logic              abort,
  input  logic              abort_en,
  input  logic [NCH*AW-1:0] src_addr,
  input  logic [NCH*AW-1:0] dst_addr,
  input  logic [NCH*CW-1:0] xfer_cnt,
  input  logic [2*NCH-1:0]  src_step,
  input  logic [2*NCH-1:0]  dst_step,
  input  logic [NCH-1:0]    src_byte,
  input  logic [NCH-1:0]    dst_byte,
  input  logic [3*NCH-1:0]  mode,
  input  logic              vec_rd,
  output logic [VW-1:0]     vec,
  output logic [NCH-1:0]    en_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [AW-1:0]     mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              cpu_hold
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_WRITE, S_WAIT, S_GAP} st_t;

  st_t            st;
  logic [CHW-1:0] cur, last, pick, vsel;
  logic           found, vhit, gcnt;
  logic [1:0]     bcnt;
  logic [15:0]    dbuf;
  logic [NCH-1:0] en, pend, flag, trig_q, req;
  logic [AW-1:0]  wsrc [NCH];
  logic [AW-1:0]  wdst [NCH];
  logic [CW-1:0]  wcnt [NCH];
  logic [AW-1:0]  c_src [NCH];
  logic [AW-1:0]  c_dst [NCH];
  logic [CW-1:0]  c_cnt [NCH];
  logic [1:0]     c_ss [NCH];
  logic [1:0]     c_ds [NCH];
  logic [2:0]     c_md [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_cfg
    assign c_src[g] = src_addr[g*AW +: AW];
    assign c_dst[g] = dst_addr[g*AW +: AW];
    assign c_cnt[g] = xfer_cnt[g*CW +: CW];
    assign c_ss[g]  = src_step[2*g +: 2];
    assign c_ds[g]  = dst_step[2*g +: 2];
    assign c_md[g]  = mode[3*g +: 3];
  end

  wire [1:0] kind = c_md[cur][1:0];
  wire       rep  = c_md[cur][2];
  wire       abt  = abort & abort_en;
  wire       last_unit = (wcnt[cur] == CW'(1));

  assign req       = pend & en;
  assign en_o      = en;
  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = mem_we ? wdst[cur] : wsrc[cur];
  assign mem_byte  = mem_we ? dst_byte[cur] : src_byte[cur];
  assign mem_wdata = dbuf;
  assign cpu_hold  = mem_req || (st == S_WAIT);

  function automatic logic [AW-1:0] stepa(input logic [AW-1:0] a, input logic [1:0] m, input logic b);
    case (m)
      2'd1:    stepa = a + (b ? AW'(1) : AW'(2));
      2'd2:    stepa = a - (b ? AW'(1) : AW'(2));
      default: stepa = a;
    endcase
  endfunction

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NCH; k++)
      if (!found && req[rr_en ? (int'(last) + 1 + k) % NCH : k]) begin
        found = 1'b1;
        pick  = CHW'(rr_en ? (int'(last) + 1 + k) % NCH : k);
      end
  end

  always_comb begin
    vec  = '0;
    vsel = '0;
    vhit = |(flag & ie);
    for (int i = NCH-1; i >= 0; i--)
      if (flag[i] && ie[i]) begin
        vec  = VW'(2*(i+1));
        vsel = CHW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; last <= '0; gcnt <= 1'b0; bcnt <= '0; dbuf <= '0;
      en <= '0; pend <= '0; flag <= '0; trig_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        wsrc[i] <= '0; wdst[i] <= '0; wcnt[i] <= '0;
      end
    end else begin
      trig_q <= trig;
      if (vec_rd && vhit) flag[vsel] <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        if (en_clr[i]) en[i] <= 1'b0;
        if (en_set[i]) begin
          en[i] <= 1'b1; pend[i] <= 1'b0;
          wsrc[i] <= c_src[i]; wdst[i] <= c_dst[i]; wcnt[i] <= c_cnt[i];
        end else if (trig[i] && !trig_q[i] && en[i] && c_cnt[i] != '0 &&
                     !(st != S_IDLE && int'(cur) == i && c_md[i][1:0] != 2'd0))
          pend[i] <= 1'b1;
      end
      case (st)
        S_IDLE: if (found) begin
          cur <= pick; pend[pick] <= 1'b0; bcnt <= '0; st <= S_READ;
        end
        S_READ: if (mem_ready) begin
          dbuf <= src_byte[cur] ? {8'h00, mem_rdata[7:0]} : mem_rdata;
          st   <= S_WRITE;
        end
        S_WRITE: if (mem_ready) st <= S_WAIT;
        S_WAIT: begin
          wsrc[cur] <= stepa(wsrc[cur], c_ss[cur], src_byte[cur]);
          wdst[cur] <= stepa(wdst[cur], c_ds[cur], dst_byte[cur]);
          bcnt <= bcnt + 2'd1;
          if (last_unit) begin
            wcnt[cur] <= c_cnt[cur];
            flag[cur] <= 1'b1;
            if (!rep) en[cur] <= 1'b0;
            else if (kind == 2'd2) pend[cur] <= 1'b1;
          end else
            wcnt[cur] <= wcnt[cur] - CW'(1);
          if (abt) begin
            en[cur] <= 1'b0; pend[cur] <= 1'b0;
          end
          if (kind == 2'd0 || last_unit || abt || !en[cur]) begin
            st <= S_IDLE; last <= cur;
          end else if (kind == 2'd2 && bcnt == 2'd3) begin
            st <= S_GAP; gcnt <= 1'b0;
          end else
            st <= S_READ;
        end
        S_GAP: if (gcnt) st <= S_READ; else gcnt <= 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma3_chk #(
  parameter int NCH = 3,
  parameter int AW  = 8,
  localparam int VW = $clog2(2*NCH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          cpu_hold,
  input logic [VW-1:0] vec
);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_write_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));
  assert_wait_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> (!mem_req && cpu_hold));
  assert_bus_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_hold);
  assert_vec_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == '0) || (!vec[0] && int'(vec) <= 2*NCH));
endmodule

bind dma3 dma3_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .cpu_hold(cpu_hold), .vec(vec)
);

// File: tb/tb_dma3.sv
module tb_dma3;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3, AW = 8, CW = 8, VW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] trig = '0, en_set = '0, en_clr = '0, ie = '1;
  logic rr_en = 1'b0, abort = 1'b0, abort_en = 1'b0, vec_rd = 1'b0;
  logic [NCH*AW-1:0] src_addr = '0, dst_addr = '0;
  logic [NCH*CW-1:0] xfer_cnt = '0;
  logic [2*NCH-1:0] src_step = '0, dst_step = '0;
  logic [NCH-1:0] src_byte = '0, dst_byte = '0;
  logic [3*NCH-1:0] mode = '0;
  logic [VW-1:0] vec;
  logic [NCH-1:0] en_o;
  logic mem_req, mem_we, mem_byte, cpu_hold;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic mem_ready = 1'b1;
  logic stall_on = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] snap [256];
  int wcount = 0;
  int wlog [1024];
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma3 #(.NCH(NCH), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .en_set(en_set), .en_clr(en_clr), .ie(ie),
    .rr_en(rr_en), .abort(abort), .abort_en(abort_en), .src_addr(src_addr),
    .dst_addr(dst_addr), .xfer_cnt(xfer_cnt), .src_step(src_step), .dst_step(dst_step),
    .src_byte(src_byte), .dst_byte(dst_byte), .mode(mode), .vec_rd(vec_rd), .vec(vec),
    .en_o(en_o), .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .cpu_hold(cpu_hold));

  assign mem_rdata = mem_byte ? {8'h00, mem[mem_addr]} : {mem[8'(mem_addr + 8'd1)], mem[mem_addr]};

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ready) begin
      mem[mem_addr] <= mem_wdata[7:0];
      if (!mem_byte) mem[8'(mem_addr + 8'd1)] <= mem_wdata[15:8];
      wlog[wcount % 1024] <= int'(mem_addr);
      wcount <= wcount + 1;
    end
    mem_ready <= stall_on ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int sword(input int a);
    return {snap[(a+1) % 256], snap[a % 256]};
  endfunction

  function automatic int mword(input int a);
    return {mem[(a+1) % 256], mem[a % 256]};
  endfunction

  task automatic take_snap();
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
  endtask

  task automatic cfg(input int ch, input int s, input int d, input int n,
                     input int ss, input int ds, input int sb, input int db, input int md);
    src_addr[ch*AW +: AW] = AW'(s);
    dst_addr[ch*AW +: AW] = AW'(d);
    xfer_cnt[ch*CW +: CW] = CW'(n);
    src_step[2*ch +: 2] = 2'(ss);
    dst_step[2*ch +: 2] = 2'(ds);
    src_byte[ch] = sb[0];
    dst_byte[ch] = db[0];
    mode[3*ch +: 3] = 3'(md);
    en_set[ch] = 1'b1;
    cyc(1);
    en_set[ch] = 1'b0;
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    trig = m; cyc(1); trig = '0;
  endtask

  task automatic off(input int ch);
    en_clr[ch] = 1'b1; cyc(1); en_clr[ch] = 1'b0;
  endtask

  task automatic rd_vec();
    vec_rd = 1'b1; cyc(1); vec_rd = 1'b0;
  endtask

  task automatic clr_flags();
    ie = '1;
    repeat (4) rd_vec();
  endtask

  initial begin
    int base, mis, gap, seen, w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    cyc(3);
    chk("R9 reset vec", int'(vec), 0);
    chk("R4 reset enables", int'(en_o), 0);
    chk("R10 reset bus", int'({mem_req, cpu_hold}), 0);
    rst_n = 1'b1;
    cyc(2);
    stall_on = 1'b1;

    // R1 R2 R4: block word copy, increment both sides
    take_snap();
    cfg(0, 'h10, 'h80, 4, 1, 1, 0, 0, 1);
    fire(3'b001); cyc(120);
    mis = 0;
    for (int k = 0; k < 4; k++) if (mword('h80 + 2*k) != sword('h10 + 2*k)) mis++;
    chk("R1 block copy mismatches", mis, 0);
    chk("R4 enable cleared after block", int'(en_o[0]), 0);
    chk("R2 flag vector ch0", int'(vec), 2);
    rd_vec();
    chk("R9 read clears flag", int'(vec), 0);

    // R2: repeated block continues working addresses, count reloads
    take_snap();
    cfg(0, 'h20, 'h90, 2, 1, 1, 0, 0, 5);
    fire(3'b001); cyc(80); fire(3'b001); cyc(80);
    mis = 0;
    for (int k = 0; k < 4; k++) if (mword('h90 + 2*k) != sword('h20 + 2*k)) mis++;
    chk("R2 repeated block continues addresses", mis, 0);
    chk("R4 repeated keeps enable", int'(en_o[0]), 1);
    off(0); clr_flags();

    // R3: zero count
    base = wcount;
    cfg(1, 'h30, 'hA0, 0, 1, 1, 0, 0, 1);
    fire(3'b010); cyc(40);
    chk("R3 zero count writes", wcount - base, 0);
    chk("R3 zero count no flag", int'(vec), 0);
    off(1);

    // R4: single mode, one unit per trigger
    base = wcount;
    cfg(1, 'h30, 'hA0, 2, 1, 1, 0, 0, 0);
    fire(3'b010); cyc(40);
    chk("R4 single one unit", wcount - base, 1);
    chk("R4 single still enabled", int'(en_o[1]), 1);
    fire(3'b010); cyc(40);
    chk("R4 single second unit", wcount - base, 2);
    chk("R4 single enable cleared", int'(en_o[1]), 0);
    chk("R9 vector ch1", int'(vec), 4);
    clr_flags();

    // R7: width conversion
    mem['hB2] = 8'h5A;
    take_snap();
    cfg(2, 'h40, 'hB0, 2, 1, 1, 0, 1, 1);
    fire(3'b100); cyc(80);
    chk("R7 word to byte first", int'(mem['hB0]), int'(snap['h40]));
    chk("R7 word to byte second", int'(mem['hB1]), int'(snap['h42]));
    chk("R7 word to byte untouched", int'(mem['hB2]), 'h5A);
    mem['hC1] = 8'hFF; mem['hC3] = 8'hFF;
    take_snap();
    cfg(2, 'h50, 'hC0, 2, 1, 1, 1, 0, 1);
    fire(3'b100); cyc(80);
    chk("R7 byte to word low0", int'(mem['hC0]), int'(snap['h50]));
    chk("R7 byte to word high0", int'(mem['hC1]), 0);
    chk("R7 byte to word low1", int'(mem['hC2]), int'(snap['h51]));
    chk("R7 byte to word high1", int'(mem['hC3]), 0);
    clr_flags();

    // R1: fixed source, decrementing destination
    take_snap(); base = wcount;
    cfg(0, 'h60, 'hD6, 3, 0, 2, 0, 0, 1);
    fire(3'b001); cyc(100);
    chk("R1 dec addr 0", wlog[base], 'hD6);
    chk("R1 dec addr 1", wlog[base+1], 'hD4);
    chk("R1 dec addr 2", wlog[base+2], 'hD2);
    chk("R1 fixed source data", mword('hD2), sword('h60));
    clr_flags();

    // R8: fixed priority
    stall_on = 1'b0; rr_en = 1'b0; base = wcount;
    cfg(0, 'h00, 'hE0, 1, 1, 1, 0, 0, 0);
    cfg(2, 'h00, 'hE8, 1, 1, 1, 0, 0, 0);
    fire(3'b101); cyc(30);
    chk("R8 fixed order first", wlog[base], 'hE0);
    chk("R8 fixed order second", wlog[base+1], 'hE8);
    // R8: rotating priority
    rr_en = 1'b1;
    cfg(0, 'h00, 'hE0, 1, 1, 1, 0, 0, 0);
    fire(3'b001); cyc(20);
    base = wcount;
    cfg(0, 'h00, 'hE0, 1, 1, 1, 0, 0, 0);
    cfg(1, 'h00, 'hEA, 1, 1, 1, 0, 0, 0);
    fire(3'b011); cyc(30);
    chk("R8 rotating order first", wlog[base], 'hEA);
    rr_en = 1'b0;
    // R8: no preemption
    base = wcount;
    cfg(2, 'h00, 'hF0, 4, 1, 1, 0, 0, 1);
    cfg(0, 'h00, 'hE4, 1, 1, 1, 0, 0, 0);
    fire(3'b100); cyc(3); fire(3'b001); cyc(40);
    chk("R8 block not preempted", wlog[base+3], 'hF6);
    chk("R8 waiting channel after block", wlog[base+4], 'hE4);
    clr_flags();

    // R10: cycle timing of one unit
    cfg(0, 'h00, 'hE0, 1, 1, 1, 0, 0, 0);
    trig[0] = 1'b1; cyc(1); trig[0] = 1'b0;
    chk("R10 sync cycle no request", int'(mem_req), 0);
    cyc(1);
    chk("R10 read phase", int'({mem_req, mem_we}), 2);
    cyc(1);
    chk("R10 write phase", int'({mem_req, mem_we}), 3);
    cyc(1);
    chk("R10 wait cycle", int'({mem_req, cpu_hold}), 1);
    cyc(1);
    chk("R10 released", int'(cpu_hold), 0);
    clr_flags();

    // R5: trigger during repeated block ignored
    stall_on = 1'b1; base = wcount;
    cfg(1, 'h00, 'hE0, 4, 1, 1, 0, 0, 5);
    fire(3'b010); cyc(4); fire(3'b010); cyc(120);
    chk("R5 retrigger ignored", wcount - base, 4);
    chk("R5 repeated still enabled", int'(en_o[1]), 1);
    off(1); clr_flags();

    // R6: burst gap
    base = wcount; gap = 0; seen = 0;
    cfg(2, 'h00, 'hE0, 8, 1, 1, 0, 0, 2);
    fire(3'b100);
    for (int t = 0; t < 400 && vec == 0; t++) begin
      cyc(1);
      if (mem_req) seen = 1;
      if (seen && vec == 0 && !cpu_hold) begin
        gap++;
        if (mem_req) gap += 100;
      end
    end
    chk("R6 burst free cycles", gap, 2);
    chk("R6 burst unit count", wcount - base, 8);
    chk("R6 burst enable cleared", int'(en_o[2]), 0);
    clr_flags();
    // R6: repeated burst runs until disabled
    base = wcount;
    cfg(2, 'h00, 'hE0, 2, 0, 0, 0, 0, 6);
    fire(3'b100); cyc(80);
    off(2); cyc(40);
    chk("R6 repeated burst restarted", int'(wcount - base > 2), 1);
    w0 = wcount; cyc(60);
    chk("R6 repeated burst stopped", wcount - w0, 0);
    clr_flags();

    // R9: masking and selective clear
    cfg(1, 'h00, 'hE0, 1, 1, 1, 0, 0, 0);
    cfg(2, 'h00, 'hE2, 1, 1, 1, 0, 0, 0);
    fire(3'b110); cyc(60);
    chk("R9 lowest enabled", int'(vec), 4);
    ie = 3'b101; cyc(1);
    chk("R9 masked channel ignored", int'(vec), 6);
    rd_vec();
    chk("R9 read clears reported", int'(vec), 0);
    ie = 3'b111; cyc(1);
    chk("R9 masked flag survived", int'(vec), 4);
    clr_flags();

    // R11: abort
    stall_on = 1'b0; abort_en = 1'b1; base = wcount;
    cfg(0, 'h00, 'hE0, 8, 1, 1, 0, 0, 1);
    fire(3'b001); cyc(8);
    abort = 1'b1; cyc(6); abort = 1'b0; cyc(40);
    chk("R11 abort stopped early", int'((wcount - base) > 0 && (wcount - base) < 8), 1);
    chk("R11 abort clears enable", int'(en_o[0]), 0);
    abort_en = 1'b0; base = wcount;
    cfg(0, 'h00, 'hE0, 8, 1, 1, 0, 0, 1);
    fire(3'b001); cyc(8);
    abort = 1'b1; cyc(6); abort = 1'b0; cyc(40);
    chk("R11 gated abort no effect", wcount - base, 8);
    clr_flags();

    // R1 R2: random block copies
    stall_on = 1'b1;
    for (int it = 0; it < 8; it++) begin
      int ch, n, s, d;
      ch = $urandom % 3; n = 1 + $urandom % 6;
      s = 2 * ($urandom % 20); d = 'h80 + 2 * ($urandom % 20);
      take_snap();
      cfg(ch, s, d, n, 1, 1, 0, 0, 1);
      fire(3'(1 << ch)); cyc(40 * n + 40);
      mis = 0;
      for (int k = 0; k < n; k++) if (mword(d + 2*k) != sword(s + 2*k)) mis++;
      chk("R1 random block copy", mis, 0);
      chk("R2 random flag vector", int'(vec), 2*(ch+1));
      clr_flags();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule